// File: doc/BRIEF.md
# Byte-Oriented Synchronous Serial Transmitter

This block turns parallel data characters into a synchronous serial stream. The bit clock is shared with the far-end receiver, and the block advances by one bit on every cycle in which a bit-clock enable is high. Characters carry no start or stop framing and follow each other with no gap. Each character goes out least significant bit first.

When no host character is waiting at a character boundary, the transmitter fills the line with a complete sync pattern. The pattern is taken right-justified from two 8-bit sync registers, and a mode input selects a length of 6, 8 or 16 bits. A host character is accepted only at a boundary, through a valid/ready handshake, so a character that arrives during a pattern waits until that pattern has been sent in full. While the transmitter is disabled, the line rests high. Once it is enabled, it always opens with a sync pattern.

Top module: `sync_tx`

## Requirements
- R1: While `enable` is low, `txd` is 1 and `data_ready` is 0, whatever `bit_en` and `data_valid` do. The same holds after reset.
- R2: After `enable` rises, the first character sent is a sync pattern, even when `data_valid` is already high.
- R3: With `sync_mode` = 2'b00, the idle pattern is `sync_lo[7:0]`, sent bit 0 first.
- R4: With `sync_mode` = 2'b01, the idle pattern is `sync_lo[5:0]` only, sent bit 0 first. Bits 7:6 are never sent.
- R5: With `sync_mode` = 2'b10, the idle pattern is 16 bits: `sync_lo` bit 0 first, then `sync_hi` bit 0 first. Code 2'b11 behaves like 2'b00.
- R6: A data character is 8 bits, sent bit 0 first. Successive characters and patterns follow each other with no idle bit between them.
- R7: A character is accepted in a cycle where `data_valid` and `data_ready` are both high. `data_ready` is high only in a `bit_en` cycle at a character boundary, once per character.
- R8: A character that becomes valid during a sync pattern is held off until that pattern has been sent in full, and is then sent immediately after it.
- R9: While the block is enabled, `txd` changes only on the clock edge of a cycle in which `bit_en` is high.
- R10: The sync registers and `sync_mode` are captured when a pattern starts. Changing them during a pattern affects only the next pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Transmitter on; when low the line rests high |
| bit_en | input | 1 | One-cycle pulse per serial bit time (shared bit clock) |
| sync_mode | input | 2 | Sync length: 00 = 8, 01 = 6, 10 = 16, 11 = 8 |
| sync_lo | input | 8 | Primary sync register, right-justified |
| sync_hi | input | 8 | Secondary sync register, used in 16-bit mode |
| data_in | input | 8 | Data character |
| data_valid | input | 1 | Data character is available |
| data_ready | output | 1 | Character is taken this cycle when valid is high |
| txd | output | 1 | Serial data output |

## Verification
A bit counter that is off by one shifts every character boundary. That shows up in the first pattern or character after enable: bits are lost or repeated, and `data_ready` appears one bit time early or late. A shift register that is loaded wrongly corrupts the very next bit on `txd`. A mistake in the boundary decision, such as taking data mid-pattern or ignoring it at a boundary, shows up within one pattern length, as a truncated sync or a character sent in the wrong place. The bench compares every serial bit against a stream built from the requirements. It also counts handshakes, so such faults surface within the first 6 to 16 bit times of the scenario that exercises them.

// File: rtl/sync_tx.sv
module sync_tx #(
  parameter int DATA_W  = 8,
  parameter int SYNC_W  = 8,
  parameter int SHORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              bit_en,
  input  logic [1:0]        sync_mode,
  input  logic [SYNC_W-1:0] sync_lo,
  input  logic [SYNC_W-1:0] sync_hi,
  input  logic [DATA_W-1:0] data_in,
  input  logic              data_valid,
  output logic              data_ready,
  output logic              txd
);
  localparam int SHW = (2*SYNC_W > DATA_W) ? 2*SYNC_W : DATA_W;
  localparam int CW  = $clog2(SHW + 1);

  logic [SHW-1:0] shreg;
  logic [CW-1:0]  cnt;
  logic           started;
  logic           txd_q;
  logic [SHW-1:0] pat, load_word;
  logic [CW-1:0]  pat_len, load_len;

  wire boundary  = (cnt == '0);
  assign data_ready = enable && started && bit_en && boundary;
  wire take_data = data_ready && data_valid;
  assign txd = txd_q;

  always_comb begin
    case (sync_mode)
      2'b01: begin
        pat     = SHW'(sync_lo[SHORT_W-1:0]);
        pat_len = CW'(SHORT_W);
      end
      2'b10: begin
        pat     = SHW'({sync_hi, sync_lo});
        pat_len = CW'(2*SYNC_W);
      end
      default: begin
        pat     = SHW'(sync_lo);
        pat_len = CW'(SYNC_W);
      end
    endcase
  end

  assign load_word = take_data ? SHW'(data_in) : pat;
  assign load_len  = take_data ? CW'(DATA_W) : pat_len;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      txd_q   <= 1'b1;
      cnt     <= '0;
      started <= 1'b0;
      shreg   <= '0;
    end else if (bit_en) begin
      if (boundary) begin
        txd_q   <= load_word[0];
        shreg   <= load_word >> 1;
        cnt     <= load_len - CW'(1);
        started <= 1'b1;
      end else begin
        txd_q <= shreg[0];
        shreg <= shreg >> 1;
        cnt   <= cnt - CW'(1);
      end
    end
  end

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> txd);

  a_r2_first_is_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !started) |-> !data_ready);

  a_r6_first_data_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && data_ready) |=> (txd == $past(data_in[0])));

  a_r9_change_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !bit_en) |=> $stable(txd));
endmodule

// File: tb/tb_sync_tx.sv
module tb_sync_tx;
  logic clk = 0, rst_n = 0, enable = 0, bit_en = 0;
  logic [1:0] sync_mode = 2'b00;
  logic [7:0] sync_lo = 8'h16, sync_hi = 8'h00, data_in = 8'h00;
  logic data_valid = 0;
  logic data_ready, txd;

  sync_tx dut (.clk(clk), .rst_n(rst_n), .enable(enable), .bit_en(bit_en),
    .sync_mode(sync_mode), .sync_lo(sync_lo), .sync_hi(sync_hi),
    .data_in(data_in), .data_valid(data_valid), .data_ready(data_ready), .txd(txd));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic exp_b [0:127];
  logic got_b [0:127];
  int exp_n, got_n;
  logic [7:0] feed [0:7];
  int feed_n, feed_idx, accepts;
  logic stable_bad;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      exp_b[exp_n] = v[i];
      exp_n++;
    end
  endtask

  task automatic update_feed();
    data_valid = (feed_idx < feed_n);
    data_in = (feed_idx < feed_n) ? feed[feed_idx] : 8'h00;
  endtask

  task automatic tick();
    logic acc;
    logic held;
    @(negedge clk);
    bit_en = 1;
    #0.1;
    acc = data_ready && data_valid;
    @(negedge clk);
    bit_en = 0;
    got_b[got_n] = txd;
    got_n++;
    held = txd;
    if (acc) begin
      accepts++;
      feed_idx++;
    end
    update_feed();
    @(negedge clk);
    if (txd !== held || data_ready) stable_bad = 1;
    @(negedge clk);
    if (txd !== held || data_ready) stable_bad = 1;
  endtask

  task automatic start(input logic [1:0] m, input logic [7:0] lo, input logic [7:0] hi);
    enable = 0;
    @(negedge clk);
    @(negedge clk);
    sync_mode = m; sync_lo = lo; sync_hi = hi;
    exp_n = 0; got_n = 0; accepts = 0; stable_bad = 0;
    feed_idx = 0;
    update_feed();
    enable = 1;
  endtask

  task automatic compare(input string req);
    int bad = -1;
    for (int i = 0; i < exp_n; i++)
      if (bad < 0 && got_b[i] !== exp_b[i]) bad = i;
    chk(bad < 0 && got_n == exp_n, req, bad, -1);
    chk(!stable_bad, "R9", stable_bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(txd === 1'b1, "R1", txd, 1);
    chk(data_ready === 1'b0, "R1", data_ready, 0);
  endtask

  task automatic t_disabled();
    enable = 0; feed[0] = 8'h55; feed_n = 1; feed_idx = 0; update_feed();
    stable_bad = 0; got_n = 0;
    for (int i = 0; i < 6; i++) tick();
    for (int i = 0; i < 6; i++) chk(got_b[i] === 1'b1, "R1", got_b[i], 1);
    chk(!stable_bad, "R1", stable_bad, 0);
    feed_n = 0;
  endtask

  task automatic t_sync8();
    feed_n = 0;
    start(2'b00, 8'h16, 8'h00);
    push(16'h16, 8); push(16'h16, 8); push(16'h16, 8);
    for (int i = 0; i < 24; i++) tick();
    compare("R3");
    chk(accepts == 0, "R7", accepts, 0);
  endtask

  task automatic t_data_b2b();
    feed[0] = 8'hA5; feed[1] = 8'h3C; feed_n = 2;
    start(2'b00, 8'h16, 8'h00);
    push(16'h16, 8); push(16'hA5, 8); push(16'h3C, 8); push(16'h16, 8);
    for (int i = 0; i < 32; i++) tick();
    compare("R2 R6");
    chk(accepts == 2, "R7", accepts, 2);
    feed_n = 0;
  endtask

  task automatic t_sync6();
    feed_n = 0;
    start(2'b01, 8'hE9, 8'h00);
    push(16'h29, 6); push(16'h29, 6); push(16'h29, 6);
    for (int i = 0; i < 18; i++) tick();
    compare("R4");
  endtask

  task automatic t_sync16();
    feed_n = 0;
    start(2'b10, 8'h4B, 8'hD2);
    push(16'hD24B, 16); push(16'hD24B, 16);
    for (int i = 0; i < 32; i++) tick();
    compare("R5");
  endtask

  task automatic t_mode11();
    feed_n = 0;
    start(2'b11, 8'h9C, 8'hFF);
    push(16'h9C, 8); push(16'h9C, 8);
    for (int i = 0; i < 16; i++) tick();
    compare("R5");
  endtask

  task automatic t_midwait();
    feed_n = 0;
    start(2'b01, 8'h2A, 8'h00);
    push(16'h2A, 6); push(16'h81, 8); push(16'h2A, 6);
    for (int i = 0; i < 3; i++) tick();
    feed[0] = 8'h81; feed_n = 1; update_feed();
    for (int i = 0; i < 17; i++) tick();
    compare("R8");
    chk(accepts == 1, "R8", accepts, 1);
    feed_n = 0;
  endtask

  task automatic t_capture();
    feed_n = 0;
    start(2'b00, 8'hF0, 8'h5A);
    push(16'hF0, 8); push(16'h5A0F, 16);
    for (int i = 0; i < 2; i++) tick();
    sync_lo = 8'h0F; sync_mode = 2'b10;
    for (int i = 0; i < 22; i++) tick();
    compare("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_sync8();
    t_data_b2b();
    t_sync6();
    t_sync16();
    t_mode11();
    t_midwait();
    t_capture();
    enable = 0;
    @(negedge clk); @(negedge clk);
    chk(txd === 1'b1, "R1", txd, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule